// File: doc/BRIEF.md
# I/O-to-Memory Decrementing Transfer Sequencer

This block carries out a CPU-style block input operation. On a start strobe it takes copies of a byte counter (B), an I/O port index (C) and a memory pointer (HL). For each transfer it reads one byte from the I/O port addressed by C. It then writes that byte to memory at the address held in HL. After the write it decrements B, C and HL together and updates a zero flag and a data-sign flag.

Two forms are supported. The single-step form moves exactly one byte. The repeat form keeps moving bytes until the counter reaches zero. An address-width input picks how HL decrements: as a full 24-bit pointer, or as a 16-bit pointer whose upper byte stays fixed. A per-operation override can replace that choice, and it costs one extra cycle. The sequencer runs on a fixed cycle schedule: a fixed overhead followed by three cycles per byte. A done pulse marks the last cycle, and during that cycle the register and flag outputs already show their final values.

Top module: `io_blkin_seq`

## Requirements
- R1: During the I/O read strobe, ioAddr[7:0] carries the current port index C and ioAddr[15:8] is zero.
- R2: Each transfer asserts ioRdStb for one cycle. In the next cycle it asserts memWrStb for one cycle, with memAddr equal to the current HL and memWrData equal to the byte sampled on ioRdData in the read cycle.
- R3: After each transfer B and C each decrement by one modulo 256, so 0x00 wraps to 0xFF.
- R4: In wide mode HL decrements as a 24-bit value. In narrow mode only HL[15:0] decrements (wrapping 0x0000 to 0xFFFF) and HL[23:16] is held.
- R5: The effective mode is ovrWide when ovrEn is 1 and addrWide otherwise (1 = wide, 0 = narrow). ovrEn = 1 adds exactly one cycle to the operation.
- R6: After each transfer, zFlag is 1 exactly when the decremented B is zero, and nFlag equals bit 7 of the byte just transferred. Both flags hold their values until the next transfer.
- R7: With repeatMode = 0, exactly one transfer is made. doneStb is high for one cycle, in cycle 5 counting the start cycle as cycle 1 (cycle 6 with ovrEn = 1), and busy is low in the following cycle.
- R8: With repeatMode = 1, transfers continue until the decremented B is zero, so a start value of B = 0 gives 256 transfers. doneStb comes in cycle 2 + 3n for n transfers (3 + 3n with ovrEn = 1).
- R9: startStb has no effect while busy is high: the running operation's registers, transfers and timing are unchanged.
- R10: After reset, busy, ioRdStb, memWrStb, doneStb, bOut, cOut, hlOut, zFlag and nFlag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStb | input | 1 | Starts an operation when idle |
| repeatMode | input | 1 | 1 = repeat until counter is zero, 0 = single transfer |
| addrWide | input | 1 | Default pointer mode, 1 = 24-bit, 0 = 16-bit |
| ovrEn | input | 1 | Override the pointer mode for this operation (one extra cycle) |
| ovrWide | input | 1 | Pointer mode used when ovrEn is 1 |
| bIn | input | 8 | Initial byte counter |
| cIn | input | 8 | Initial I/O port index |
| hlIn | input | 24 | Initial memory pointer |
| ioAddr | output | 16 | I/O address, zero upper byte and port index below |
| ioRdStb | output | 1 | I/O read strobe |
| ioRdData | input | 8 | I/O read data, sampled at the end of the read cycle |
| memAddr | output | 24 | Memory write address |
| memWrStb | output | 1 | Memory write strobe |
| memWrData | output | 8 | Memory write data |
| busy | output | 1 | Operation in progress |
| doneStb | output | 1 | High in the final cycle of an operation |
| bOut | output | 8 | Current byte counter |
| cOut | output | 8 | Current port index |
| hlOut | output | 24 | Current memory pointer |
| zFlag | output | 1 | Zero flag |
| nFlag | output | 1 | Data-sign flag |

## Verification
The bench targets these corner cases:
- **Counter starting at zero in the repeat form.** It must give 256 transfers and finish in cycle 770. A design that tests B before the decrement would stop at once or never stop.
- **HL crossing a 16-bit boundary in narrow mode.** 0x120000 must become 0x12FFFF. A design that borrows into the upper byte would write the wrong memory bank on later transfers.
- **Port index wrapping from 0x00.** C must become 0xFF, and the override must add exactly one cycle. A design that got either wrong would show up as a misplaced I/O address or a cycle count that is off by one.
- **Start strobe during a run.** This is driven with different register values. A design that reloads its registers mid-run would write to unexpected addresses.

// File: rtl/blkin_pkg.sv
package blkin_pkg;

  // strobes handed from the control FSM to the datapath
  typedef struct packed {
    logic loadRegs;  // capture start operands
    logic ioRd;      // I/O read cycle, capture data
    logic memWr;     // memory write cycle
    logic stepDec;   // decrement B, C, HL and update flags
    logic done;      // final cycle of the operation
  } blkStb_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OVH,
    ST_PFX,
    ST_RD,
    ST_WR,
    ST_CHK
  } blkState_t;

endpackage

// File: rtl/blkin_ctrl.sv
module blkin_ctrl
  import blkin_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startStb,
  input  logic    repeatMode,
  input  logic    ovrEn,
  input  logic    bIsZero,
  output blkStb_t stb,
  output logic    busy
);

  blkState_t state, stateNext;
  logic      repReg;
  logic      pfxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      repReg <= 1'b0;
      pfxReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && startStb) begin
        repReg <= repeatMode;
        pfxReg <= ovrEn;
      end
    end
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    unique case (state)
      ST_IDLE: begin
        if (startStb) begin
          stb.loadRegs = 1'b1;
          stateNext    = ST_OVH;
        end
      end
      ST_OVH:  stateNext = pfxReg ? ST_PFX : ST_RD;
      ST_PFX:  stateNext = ST_RD;
      ST_RD: begin
        stb.ioRd  = 1'b1;
        stateNext = ST_WR;
      end
      ST_WR: begin
        stb.memWr   = 1'b1;
        stb.stepDec = 1'b1;
        stateNext   = ST_CHK;
      end
      ST_CHK: begin
        if (!repReg || bIsZero) begin
          stb.done  = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stateNext = ST_RD;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/blkin_dpath.sv
module blkin_dpath
  import blkin_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PTR_W  = 24,
  parameter int SEG_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  blkStb_t              stb,
  input  logic [CNT_W-1:0]     bIn,
  input  logic [CNT_W-1:0]     cIn,
  input  logic [PTR_W-1:0]     hlIn,
  input  logic                 wideSel,
  input  logic [DATA_W-1:0]    ioRdData,
  output logic [2*CNT_W-1:0]   ioAddr,
  output logic [PTR_W-1:0]     memAddr,
  output logic [DATA_W-1:0]    memWrData,
  output logic [CNT_W-1:0]     bOut,
  output logic [CNT_W-1:0]     cOut,
  output logic [PTR_W-1:0]     hlOut,
  output logic                 zFlag,
  output logic                 nFlag,
  output logic                 bIsZero
);

  logic [CNT_W-1:0]  bReg, cReg, bNext;
  logic [PTR_W-1:0]  hlReg, hlWideDec, hlSegDec, hlNext;
  logic [DATA_W-1:0] dataReg;
  logic              wideReg, zReg, nReg;

  always_comb hlWideDec = hlReg - PTR_W'(1);

  generate
    if (SEG_W < PTR_W) begin : g_seg
      always_comb hlSegDec = {hlReg[PTR_W-1:SEG_W], hlReg[SEG_W-1:0] - SEG_W'(1)};
    end else begin : g_flat
      always_comb hlSegDec = hlWideDec;
    end
  endgenerate

  always_comb begin
    hlNext = wideReg ? hlWideDec : hlSegDec;
    bNext  = bReg - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bReg    <= '0;
      cReg    <= '0;
      hlReg   <= '0;
      wideReg <= 1'b0;
      dataReg <= '0;
      zReg    <= 1'b0;
      nReg    <= 1'b0;
    end else begin
      if (stb.loadRegs) begin
        bReg    <= bIn;
        cReg    <= cIn;
        hlReg   <= hlIn;
        wideReg <= wideSel;
      end
      if (stb.ioRd) dataReg <= ioRdData;
      if (stb.stepDec) begin
        bReg  <= bNext;
        cReg  <= cReg - CNT_W'(1);
        hlReg <= hlNext;
        zReg  <= (bNext == '0);
        nReg  <= dataReg[DATA_W-1];
      end
    end
  end

  assign ioAddr    = {{CNT_W{1'b0}}, cReg};
  assign memAddr   = hlReg;
  assign memWrData = dataReg;
  assign bOut      = bReg;
  assign cOut      = cReg;
  assign hlOut     = hlReg;
  assign zFlag     = zReg;
  assign nFlag     = nReg;
  assign bIsZero   = (bReg == '0);

endmodule

// File: rtl/io_blkin_seq.sv
module io_blkin_seq
  import blkin_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PTR_W  = 24,
  parameter int SEG_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               startStb,
  input  logic               repeatMode,
  input  logic               addrWide,
  input  logic               ovrEn,
  input  logic               ovrWide,
  input  logic [CNT_W-1:0]   bIn,
  input  logic [CNT_W-1:0]   cIn,
  input  logic [PTR_W-1:0]   hlIn,
  output logic [2*CNT_W-1:0] ioAddr,
  output logic               ioRdStb,
  input  logic [DATA_W-1:0]  ioRdData,
  output logic [PTR_W-1:0]   memAddr,
  output logic               memWrStb,
  output logic [DATA_W-1:0]  memWrData,
  output logic               busy,
  output logic               doneStb,
  output logic [CNT_W-1:0]   bOut,
  output logic [CNT_W-1:0]   cOut,
  output logic [PTR_W-1:0]   hlOut,
  output logic               zFlag,
  output logic               nFlag
);

  blkStb_t stb;
  logic    bIsZero;
  logic    wideSel;

  // override replaces the default pointer mode for this operation
  assign wideSel = ovrEn ? ovrWide : addrWide;

  blkin_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (startStb),
    .repeatMode(repeatMode),
    .ovrEn     (ovrEn),
    .bIsZero   (bIsZero),
    .stb       (stb),
    .busy      (busy)
  );

  blkin_dpath #(
    .CNT_W (CNT_W),
    .PTR_W (PTR_W),
    .SEG_W (SEG_W),
    .DATA_W(DATA_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .bIn      (bIn),
    .cIn      (cIn),
    .hlIn     (hlIn),
    .wideSel  (wideSel),
    .ioRdData (ioRdData),
    .ioAddr   (ioAddr),
    .memAddr  (memAddr),
    .memWrData(memWrData),
    .bOut     (bOut),
    .cOut     (cOut),
    .hlOut    (hlOut),
    .zFlag    (zFlag),
    .nFlag    (nFlag),
    .bIsZero  (bIsZero)
  );

  assign ioRdStb  = stb.ioRd;
  assign memWrStb = stb.memWr;
  assign doneStb  = stb.done;

endmodule

// File: rtl/blkin_chk.sv
module blkin_chk #(
  parameter int CNT_W  = 8,
  parameter int PTR_W  = 24,
  parameter int SEG_W  = 16,
  parameter int DATA_W = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [2*CNT_W-1:0] ioAddr,
  input logic               ioRdStb,
  input logic               memWrStb,
  input logic [DATA_W-1:0]  memWrData,
  input logic               busy,
  input logic               doneStb,
  input logic [CNT_W-1:0]   bOut,
  input logic [CNT_W-1:0]   cOut,
  input logic [PTR_W-1:0]   hlOut,
  input logic               zFlag,
  input logic               nFlag
);

  AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ioRdStb |-> (ioAddr[2*CNT_W-1:CNT_W] == '0)); // R1

  AST_RD_THEN_WR: assert property (@(posedge clk) disable iff (!rstN)
    ioRdStb |=> memWrStb); // R2

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(ioRdStb && memWrStb)); // R2

  AST_CNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    memWrStb |=> (bOut == $past(bOut) - CNT_W'(1)) && (cOut == $past(cOut) - CNT_W'(1))); // R3

  AST_HL_LOW_DEC: assert property (@(posedge clk) disable iff (!rstN)
    memWrStb |=> (hlOut[SEG_W-1:0] == $past(hlOut[SEG_W-1:0]) - SEG_W'(1))); // R4

  AST_Z_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    memWrStb |=> (zFlag == (bOut == '0))); // R6

  AST_N_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    memWrStb |=> (nFlag == $past(memWrData[DATA_W-1]))); // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !busy); // R7

  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memWrStb) |=> ($stable(bOut) && $stable(cOut) && $stable(hlOut))); // R9

endmodule

bind io_blkin_seq blkin_chk #(
  .CNT_W (CNT_W),
  .PTR_W (PTR_W),
  .SEG_W (SEG_W),
  .DATA_W(DATA_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .ioAddr   (ioAddr),
  .ioRdStb  (ioRdStb),
  .memWrStb (memWrStb),
  .memWrData(memWrData),
  .busy     (busy),
  .doneStb  (doneStb),
  .bOut     (bOut),
  .cOut     (cOut),
  .hlOut    (hlOut),
  .zFlag    (zFlag),
  .nFlag    (nFlag)
);

// File: tb/io_blkin_seq_tb_top.sv
`timescale 1ns/1ps
module io_blkin_seq_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStb = 1'b0, repeatMode = 1'b0, addrWide = 1'b0, ovrEn = 1'b0, ovrWide = 1'b0;
  logic [7:0]  bIn = '0, cIn = '0;
  logic [23:0] hlIn = '0;
  logic [15:0] ioAddr;
  logic        ioRdStb, memWrStb, busy, doneStb, zFlag, nFlag;
  logic [7:0]  ioRdData, memWrData, bOut, cOut;
  logic [23:0] memAddr, hlOut;

  int errCnt = 0;
  int chkCnt = 0;

  always #10 clk = ~clk;  // 50 MHz

  function automatic logic [7:0] ioByte(input logic [7:0] idx);
    logic [7:0] m;
    m = idx * 8'd29;
    return m ^ 8'h6C;
  endfunction

  assign ioRdData = ioByte(ioAddr[7:0]);

  io_blkin_seq dut_i (
    .clk(clk), .rstN(rstN), .startStb(startStb), .repeatMode(repeatMode),
    .addrWide(addrWide), .ovrEn(ovrEn), .ovrWide(ovrWide),
    .bIn(bIn), .cIn(cIn), .hlIn(hlIn),
    .ioAddr(ioAddr), .ioRdStb(ioRdStb), .ioRdData(ioRdData),
    .memAddr(memAddr), .memWrStb(memWrStb), .memWrData(memWrData),
    .busy(busy), .doneStb(doneStb), .bOut(bOut), .cOut(cOut), .hlOut(hlOut),
    .zFlag(zFlag), .nFlag(nFlag)
  );

  typedef struct packed {
    logic [15:0] ioA;
    logic [23:0] memA;
    logic [7:0]  data;
  } xfer_t;

  xfer_t       expQ[$];
  logic [15:0] seenIo = '0;

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every memory write
  always @(negedge clk) begin : mon
    xfer_t e;
    if (rstN) begin
      if (ioRdStb) seenIo = ioAddr;
      if (memWrStb) begin
        if (expQ.size() == 0) begin
          chkEq("R2 unexpected write", 32'd1, 32'd0);
        end else begin
          e = expQ.pop_front();
          chkEq("R1 io address", {16'h0, seenIo}, {16'h0, e.ioA});
          chkEq("R2 mem address", {8'h0, memAddr}, {8'h0, e.memA});
          chkEq("R2 mem data", {24'h0, memWrData}, {24'h0, e.data});
        end
      end
    end
  end

  // driver: builds the expected transfers, starts the operation, checks the end state
  task automatic runXfer(input string name, input logic [7:0] b0, input logic [7:0] c0,
                         input logic [23:0] hl0, input bit rep, input bit wide,
                         input bit oEn, input bit oWide, input bit inject);
    logic [7:0]  b, c, d;
    logic [23:0] hl;
    bit          effWide, z, n;
    int          cnt, cyc, expCyc;
    xfer_t       it;
    b = b0; c = c0; hl = hl0; cnt = 0; z = 0; n = 0;
    effWide = oEn ? oWide : wide;
    do begin
      d = ioByte(c);
      it.ioA = {8'h00, c}; it.memA = hl; it.data = d;
      expQ.push_back(it);
      b = b - 8'd1;
      c = c - 8'd1;
      hl = effWide ? hl - 24'd1 : {hl[23:16], hl[15:0] - 16'd1};
      z = (b == 8'd0);
      n = d[7];
      cnt++;
    end while (rep && b != 8'd0);
    expCyc = 2 + (oEn ? 1 : 0) + 3 * cnt;

    bIn = b0; cIn = c0; hlIn = hl0; repeatMode = rep; addrWide = wide;
    ovrEn = oEn; ovrWide = oWide; startStb = 1'b1;
    cyc = 1;
    @(negedge clk);
    startStb = 1'b0;
    cyc = 2;
    while (!doneStb && cyc < 2000) begin
      if (inject && cyc == 3) begin
        startStb = 1'b1; bIn = 8'h33; cIn = 8'h99; hlIn = 24'hABCDEF;
        repeatMode = ~rep; ovrEn = ~oEn;
      end else begin
        startStb = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    startStb = 1'b0;

    if (rep) chkEq({name, " R8 cycle count"}, cyc, expCyc);
    else     chkEq({name, " R7 cycle count"}, cyc, expCyc);
    chkEq({name, " R3 B final"}, {24'h0, bOut}, {24'h0, b});
    chkEq({name, " R3 C final"}, {24'h0, cOut}, {24'h0, c});
    chkEq({name, " R4 HL final"}, {8'h0, hlOut}, {8'h0, hl});
    chkEq({name, " R6 Z flag"}, {31'h0, zFlag}, {31'h0, z});
    chkEq({name, " R6 N flag"}, {31'h0, nFlag}, {31'h0, n});
    chkEq({name, " R8 pending transfers"}, expQ.size(), 0);
    expQ.delete();
    @(negedge clk);
    chkEq({name, " R7 busy after done"}, {31'h0, busy}, 32'd0);
    chkEq({name, " R6 flags held"}, {30'h0, zFlag, nFlag}, {30'h0, z, n});
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
    $finish;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errCnt++;
    chkCnt++;
    $display("FAIL watchdog R7 actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chkEq("R10 strobes/busy", {28'h0, busy, ioRdStb, memWrStb, doneStb}, 32'd0);
    chkEq("R10 registers", {bOut, cOut, 16'h0}, 32'd0);
    chkEq("R10 pointer", {8'h0, hlOut}, 32'd0);
    chkEq("R10 flags", {30'h0, zFlag, nFlag}, 32'd0);

    runXfer("single narrow",        8'd5,  8'h10, 24'h123456, 0, 0, 0, 0, 0);
    runXfer("single B=1 R6",        8'd1,  8'h03, 24'h000100, 0, 1, 0, 0, 0);
    runXfer("R4 narrow boundary",   8'd3,  8'h20, 24'h120000, 0, 0, 0, 0, 0);
    runXfer("R4 wide boundary",     8'd3,  8'h20, 24'h120000, 0, 1, 0, 0, 0);
    runXfer("R3 C wrap",            8'd9,  8'h00, 24'h004000, 0, 0, 0, 0, 0);
    runXfer("R5 override narrow",   8'd2,  8'h40, 24'h340000, 0, 1, 1, 0, 0);
    runXfer("R5 override wide",     8'd2,  8'h41, 24'h340000, 0, 0, 1, 1, 0);
    runXfer("repeat B=4",           8'd4,  8'h85, 24'h200002, 1, 0, 0, 0, 0);
    runXfer("repeat B=1",           8'd1,  8'h07, 24'h00FFFF, 1, 1, 0, 0, 0);
    runXfer("R5 repeat override",   8'd6,  8'h01, 24'h560003, 1, 1, 1, 0, 0);
    runXfer("R8 repeat B=0",        8'd0,  8'hF0, 24'h780010, 1, 0, 0, 0, 0);
    runXfer("R9 start while busy",  8'd3,  8'h55, 24'h010203, 1, 1, 0, 0, 1);
    runXfer("R9 start single",      8'd7,  8'h66, 24'h0A0B0C, 0, 0, 0, 0, 1);

    finishRun();
  end

endmodule